// File: doc/BRIEF.md
# Dual-Strobe Shift/Load Register

A small register of storage stages (four by default) with two separate strobe inputs, one per operation. A select input picks the operation. With the select low, a falling edge on the shift strobe moves every stage one place toward the last stage, and the serial input enters the first stage. With the select high, a falling edge on the load strobe copies the parallel input word into all stages at once. The strobe of the operation that is not selected, and the data inputs that belong to it, do nothing.

Both strobes are treated as slow external signals. A free-running system clock samples them through synchronizer flops, and a high-to-low transition produces a single one-cycle action. All stage outputs are visible. A left shift needs no extra logic: the parallel inputs are wired from the next stage's output, and serial data enters at the last parallel bit. Several blocks chain into a longer register when the last output of one drives the serial input of the next.

Top module: `dual_strobe_shreg`

## Requirements
- R1: While `rst_n` is low, every stage is cleared to 0 on the next `clk` edge. Reset wins over any strobe action that happens at the same time.
- R2: With `sel_load`=0, a shift-strobe falling edge sets `q[0]` to `ser_in` and `q[i]` to the old `q[i-1]`. The old `q[WIDTH-1]` leaves the register.
- R3: With `sel_load`=0, falling edges on `strb_load` and any values on `par_in` leave `q` unchanged.
- R4: With `sel_load`=1, a load-strobe falling edge sets `q[i]` to `par_in[i]` for every i in one step. Bit 0 goes into the first stage.
- R5: With `sel_load`=1, falling edges on `strb_shift` and any values on `ser_in` leave `q` unchanged.
- R6: Only a high-to-low strobe transition acts. A strobe held low for any length of time causes exactly one action, and a rising edge causes none.
- R7: With the default two synchronizer stages, `q` changes at the third rising `clk` edge after the strobe falls. `sel_load`, `ser_in` and `par_in` are sampled at that same edge.
- R8: With `sel_load`=1, `par_in[i]` wired to `q[i+1]` and the serial bit on `par_in[WIDTH-1]`, each load-strobe falling edge shifts the register toward stage 0.
- R9: Two blocks with shared strobes, where the first block's `q[WIDTH-1]` drives the second block's `ser_in`, act as a single register of twice the width under shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_load | input | 1 | 0: shift strobe enabled; 1: load strobe enabled |
| strb_shift | input | 1 | Shift strobe, acts on its falling edge |
| strb_load | input | 1 | Load strobe, acts on its falling edge |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel load data, bit i to stage i |
| q | output | WIDTH | Stage outputs, bit 0 is the first stage |

## Verification
The right shift is driven with an irregular bit string, long enough for bits to cross into a cascaded second block. A broken stage link or a broken chain connection therefore shows up as a misplaced bit. Parallel loads use alternating, all-ones, all-zeros and single-bit words, so a swapped bit order or a stuck stage cannot hide. Each disabled strobe is pulsed while its data inputs hold values that differ from the stored word, which separates true gating from an accidental match. A strobe held low for many cycles shows the difference between acting once per edge and acting on the level. A left shift through externally wired parallel inputs confirms that a load moves the register in the other direction.

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_load,
  input  logic             strb_shift,
  input  logic             strb_load,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sh_sync, ld_sync;
  logic                   sh_prev, ld_prev;
  logic                   act_shift, act_load;
  logic                   do_shift, do_load;
  logic [WIDTH-1:0]       shift_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_sync <= '0;
      ld_sync <= '0;
      sh_prev <= 1'b0;
      ld_prev <= 1'b0;
    end else begin
      sh_sync <= {sh_sync[SYNC_STAGES-2:0], strb_shift};
      ld_sync <= {ld_sync[SYNC_STAGES-2:0], strb_load};
      sh_prev <= sh_sync[LAST];
      ld_prev <= ld_sync[LAST];
    end
  end

  assign act_shift = sh_prev & ~sh_sync[LAST];
  assign act_load  = ld_prev & ~ld_sync[LAST];
  assign do_shift  = act_shift & ~sel_load;
  assign do_load   = act_load & sel_load;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_link
      if (i == 0) begin : g_head
        assign shift_word[i] = ser_in;
      end else begin : g_body
        assign shift_word[i] = q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (do_load)  q <= par_in;
    else if (do_shift) q <= shift_word;
  end

endmodule

// File: rtl/dual_strobe_shreg_chk.sv
module dual_strobe_shreg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_load,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q,
  input logic             act_shift,
  input logic             act_load
);

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> q == '0);

  p_shift_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_shift && !sel_load) |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});

  p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_load && sel_load) |=> q == $past(par_in));

  p_gated_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !((act_shift && !sel_load) || (act_load && sel_load)) |=> $stable(q));

  p_single_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_shift |=> !act_shift);

  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_load |=> !act_load);

endmodule

bind dual_strobe_shreg dual_strobe_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_load (sel_load),
  .ser_in   (ser_in),
  .par_in   (par_in),
  .q        (q),
  .act_shift(act_shift),
  .act_load (act_load)
);

// File: tb/sim_dual_strobe_shreg.sv
module sim_dual_strobe_shreg;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel_load, strb_shift, strb_load, ser_in, ser_left, wire_left;
  logic [W-1:0] par_drv, par_mux, par1, q0, q1;
  logic [W-1:0] r0, r1;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  assign par_mux = wire_left ? {ser_left, q0[W-1:1]} : par_drv;

  dual_strobe_shreg #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .strb_shift(strb_shift),
    .strb_load(strb_load), .ser_in(ser_in), .par_in(par_mux), .q(q0));

  dual_strobe_shreg #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .strb_shift(strb_shift),
    .strb_load(strb_load), .ser_in(q0[W-1]), .par_in(par1), .q(q1));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_shift(input int low);
    strb_shift = 1'b0; cyc(low); strb_shift = 1'b1; cyc(4);
  endtask

  task automatic pulse_load(input int low);
    strb_load = 1'b0; cyc(low); strb_load = 1'b1; cyc(4);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cyc(3);
    r0 = '0; r1 = '0;
    chk("R1 reset stage0 block", q0, r0);
    chk("R1 reset chained block", q1, r1);
    rst_n = 1'b1; cyc(2);
  endtask

  task automatic t_shift;
    logic [6:0] bits = 7'b1001101;
    sel_load = 1'b0;
    for (int k = 0; k < 7; k++) begin
      ser_in = bits[k];
      strb_shift = 1'b0; cyc(2);
      chk("R7 no change before third edge", q0, r0);
      cyc(1);
      r1 = {r1[W-2:0], r0[W-1]};
      r0 = {r0[W-2:0], bits[k]};
      chk("R7/R2 right shift", q0, r0);
      chk("R9 cascade", q1, r1);
      strb_shift = 1'b1; cyc(4);
    end
  endtask

  task automatic t_load_ignored_mode0;
    sel_load = 1'b0;
    par_drv = ~r0; par1 = ~r1; pulse_load(5);
    chk("R3 load strobe ignored in shift mode", q0, r0);
    par_drv = 4'b0110; pulse_load(3);
    chk("R3 parallel data ignored in shift mode", q0, r0);
    chk("R3 chained block unchanged", q1, r1);
  endtask

  task automatic t_load;
    logic [W-1:0] pats [5] = '{4'b1010, 4'b0101, 4'b1111, 4'b0001, 4'b0000};
    sel_load = 1'b1;
    for (int k = 0; k < 5; k++) begin
      par_drv = pats[k]; par1 = ~pats[k];
      pulse_load(5);
      r0 = pats[k]; r1 = ~pats[k];
      chk("R4 parallel load", q0, r0);
      chk("R4 parallel load chained", q1, r1);
    end
  endtask

  task automatic t_shift_ignored_mode1;
    sel_load = 1'b1;
    par_drv = 4'b0110; par1 = 4'b1001; pulse_load(5);
    r0 = 4'b0110; r1 = 4'b1001;
    ser_in = 1'b1; pulse_shift(5);
    chk("R5 shift strobe ignored in load mode", q0, r0);
    ser_in = 1'b0; pulse_shift(3);
    chk("R5 serial data ignored in load mode", q0, r0);
  endtask

  task automatic t_edges;
    sel_load = 1'b0;
    ser_in = 1'b1;
    strb_shift = 1'b0; cyc(3);
    r1 = {r1[W-2:0], r0[W-1]};
    r0 = {r0[W-2:0], 1'b1};
    ser_in = 1'b0; cyc(10);
    chk("R6 held low acts once", q0, r0);
    strb_shift = 1'b1; cyc(6);
    chk("R6 rising edge no action", q0, r0);
    chk("R6 rising edge no action chained", q1, r1);
  endtask

  task automatic t_left;
    logic [2:0] lb = 3'b001;
    sel_load = 1'b1;
    wire_left = 1'b0;
    par_drv = 4'b0011; par1 = 4'b0000; pulse_load(5);
    r0 = 4'b0011; r1 = 4'b0000;
    wire_left = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ser_left = lb[k];
      pulse_load(5);
      r0 = {lb[k], r0[W-1:1]};
      chk("R8 wired left shift", q0, r0);
    end
    wire_left = 1'b0;
  endtask

  task automatic t_reset_prio;
    sel_load = 1'b1;
    par_drv = 4'b1111; par1 = 4'b1111;
    rst_n = 1'b0; strb_load = 1'b0; cyc(5);
    r0 = '0; r1 = '0;
    chk("R1 reset beats load", q0, r0);
    strb_load = 1'b1; cyc(2);
    rst_n = 1'b1; cyc(4);
    chk("R1 state still clear after release", q0, r0);
  endtask

  initial begin
    rst_n = 1'b0; sel_load = 1'b0; strb_shift = 1'b1; strb_load = 1'b1;
    ser_in = 1'b0; ser_left = 1'b0; wire_left = 1'b0;
    par_drv = '0; par1 = '0; r0 = '0; r1 = '0;
    cyc(2);
    t_reset;
    t_shift;
    t_load_ignored_mode0;
    t_load;
    t_shift_ignored_mode1;
    t_edges;
    t_left;
    t_reset_prio;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1..R9 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule